// File: doc/BRIEF.md
# Analog-Pin Digital I/O Port Pair with Alternate-Function Override

This block gives software digital control over a group of pins that a converter can also sample. There are two ports. Port A is sparse: only bits 4, 3, 1 and 0 reach pins. Port B has four pins on bits 3:0. Each port holds an output latch and a direction register. Both are reached through a byte-wide register bus with a two-bit address. For every pin the block drives an output value and an output enable toward the pad. Pin levels come back through a two-flop synchroniser.

Two mode inputs from the converter controller can take pins away from software control. In external-multiplexer mode, port A pins 1:0 become outputs that carry the two-bit multiplexer address. In external-trigger mode, port A pins 4:3 become inputs. Their synchronised levels are presented to the controller as trigger levels. In either mode the direction register has no effect on the pins that are taken over. A port read then returns the alternate-function values for those bits.

Top module: `anpio_port`

## Requirements
- R1: Out of reset both direction registers are zero, so every output enable is low. For a pin that no mode has taken over, direction bit 1 sets the pin's output enable and direction bit 0 clears it.
- R2: Port A bits 7:5 and bit 2 have no pin. They read as 0 from the data and direction registers (addresses 0 and 2), and their enable and output lines stay 0.
- R3: Port B bits 7:4 have no pin. They read as 0 from addresses 1 and 3, and their enable and output lines stay 0.
- R4: While `mux_mode` is 1, port A pins 1:0 have their enables forced to 1 and carry `mux_addr[1:0]`, whatever their direction bits.
- R5: While `mux_mode` is 1, a read of port A data returns `mux_addr` in bits 1:0.
- R6: While `trig_mode` is 1, port A pins 4:3 have their enables forced to 0, and `trig_lvl[1:0]` carries the synchronised levels of pins 3 and 4. While `trig_mode` is 0, `trig_lvl` is 0.
- R7: While `trig_mode` is 1, a read of port A data returns the synchronised levels of pins 4:3 in bits 4:3, whatever the direction setting.
- R8: For a pin that no mode has taken over, a data read returns the latched value when its direction bit is 1 and the synchronised pin level when its direction bit is 0.
- R9: Pin levels pass through two flops. A read sampled on the first or second clock edge after a pin changes returns the old level. A read sampled on the third edge returns the new level.
- R10: A data write always updates the output latch, even for input pins. The latched value reaches the pin's output line once the pin becomes an output or an override is released.
- R11: Address map: 0 is port A data, 1 is port B data, 2 is port A direction, 3 is port B direction. A write takes effect on the edge where it is sampled. Read data appears on the edge where the read is sampled and holds until the next read.
- R12: Out of reset the read data register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select (see R11) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mux_mode | input | 1 | External-multiplexer mode enable |
| mux_addr | input | 2 | Multiplexer address to drive on port A pins 1:0 |
| trig_mode | input | 1 | External-trigger mode enable |
| trig_lvl | output | 2 | Synchronised trigger levels (bit 0 from pin 3, bit 1 from pin 4) |
| pad_a_in | input | 8 | Port A pin levels |
| pad_a_out | output | 8 | Port A output values |
| pad_a_oe | output | 8 | Port A output enables |
| pad_b_in | input | 8 | Port B pin levels (bits 7:4 unused) |
| pad_b_out | output | 8 | Port B output values |
| pad_b_oe | output | 8 | Port B output enables |

## Verification
The assertions assume that `mux_mode`, `mux_addr` and `trig_mode` are synchronous to `clk`. They also assume that a strobed bus cycle carries a settled address and write data. The checks that compare read data with the mode inputs rely on those inputs holding their value over the read edge. The stimulus meets these conditions by changing every input only on the falling clock edge. It keeps the mode inputs steady across each read it checks, and it raises `bus_sel` for exactly one edge per access.

// File: rtl/anpio_pkg.sv
package anpio_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        SEL_DAT_A = 2'd0,
        SEL_DAT_B = 2'd1,
        SEL_DIR_A = 2'd2,
        SEL_DIR_B = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0] lat_a;
        logic [DW-1:0] dir_a;
        logic [DW-1:0] lat_b;
        logic [DW-1:0] dir_b;
        logic [DW-1:0] rdata;
    } regs_t;

endpackage

// File: rtl/anpio_sync.sv
module anpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/anpio_pinmux.sv
module anpio_pinmux #(
    parameter int          W       = 8,
    parameter logic [7:0]  MASK    = 8'h1B,
    parameter bit          MUX_EN  = 1'b1,
    parameter int          MUX_LO  = 0,
    parameter bit          TRIG_EN = 1'b1,
    parameter int          TRIG_LO = 3
) (
    input  logic [W-1:0] lat,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] sync,
    input  logic         mux_mode,
    input  logic [1:0]   mux_addr,
    input  logic         trig_mode,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] rd
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        localparam bit IS_MUX  = MUX_EN  && (i == MUX_LO  || i == MUX_LO + 1);
        localparam bit IS_TRIG = TRIG_EN && (i == TRIG_LO || i == TRIG_LO + 1);
        if (!MASK[i]) begin : g_none
            assign oe[i]  = 1'b0;
            assign out[i] = 1'b0;
            assign rd[i]  = 1'b0;
        end else if (IS_MUX) begin : g_mux
            localparam int K = i - MUX_LO;
            assign oe[i]  = mux_mode | dir[i];
            assign out[i] = mux_mode ? mux_addr[K] : lat[i];
            assign rd[i]  = mux_mode ? mux_addr[K] : (dir[i] ? lat[i] : sync[i]);
        end else if (IS_TRIG) begin : g_trig
            assign oe[i]  = ~trig_mode & dir[i];
            assign out[i] = lat[i];
            assign rd[i]  = (trig_mode || !dir[i]) ? sync[i] : lat[i];
        end else begin : g_plain
            assign oe[i]  = dir[i];
            assign out[i] = lat[i];
            assign rd[i]  = dir[i] ? lat[i] : sync[i];
        end
    end
endmodule

// File: rtl/anpio_port.sv
module anpio_port
    import anpio_pkg::*;
#(
    parameter logic [7:0] A_MASK      = 8'h1B,
    parameter logic [7:0] B_MASK      = 8'h0F,
    parameter int         MUX_LO      = 0,
    parameter int         TRIG_LO     = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          mux_mode,
    input  logic [1:0]    mux_addr,
    input  logic          trig_mode,
    output logic [1:0]    trig_lvl,
    input  logic [DW-1:0] pad_a_in,
    output logic [DW-1:0] pad_a_out,
    output logic [DW-1:0] pad_a_oe,
    input  logic [DW-1:0] pad_b_in,
    output logic [DW-1:0] pad_b_out,
    output logic [DW-1:0] pad_b_oe
);
    regs_t         regs_d, regs_q;
    logic [DW-1:0] sync_a, sync_b, rd_a, rd_b;

    anpio_sync #(.W(DW), .STAGES(SYNC_STAGES)) sync_a_i (
        .clk(clk), .rst_n(rst_n), .din(pad_a_in), .dout(sync_a));
    anpio_sync #(.W(DW), .STAGES(SYNC_STAGES)) sync_b_i (
        .clk(clk), .rst_n(rst_n), .din(pad_b_in), .dout(sync_b));

    anpio_pinmux #(.W(DW), .MASK(A_MASK), .MUX_EN(1'b1), .MUX_LO(MUX_LO),
                   .TRIG_EN(1'b1), .TRIG_LO(TRIG_LO)) mux_a_i (
        .lat(regs_q.lat_a), .dir(regs_q.dir_a), .sync(sync_a),
        .mux_mode(mux_mode), .mux_addr(mux_addr), .trig_mode(trig_mode),
        .oe(pad_a_oe), .out(pad_a_out), .rd(rd_a));

    anpio_pinmux #(.W(DW), .MASK(B_MASK), .MUX_EN(1'b0), .MUX_LO(0),
                   .TRIG_EN(1'b0), .TRIG_LO(0)) mux_b_i (
        .lat(regs_q.lat_b), .dir(regs_q.dir_b), .sync(sync_b),
        .mux_mode(1'b0), .mux_addr(2'b00), .trig_mode(1'b0),
        .oe(pad_b_oe), .out(pad_b_out), .rd(rd_b));

    always_comb begin
        regs_d = regs_q;
        if (bus_sel && bus_we) begin
            case (reg_sel_e'(bus_addr))
                SEL_DAT_A: regs_d.lat_a = bus_wdata & A_MASK;
                SEL_DAT_B: regs_d.lat_b = bus_wdata & B_MASK;
                SEL_DIR_A: regs_d.dir_a = bus_wdata & A_MASK;
                default:   regs_d.dir_b = bus_wdata & B_MASK;
            endcase
        end
        if (bus_sel && !bus_we) begin
            case (reg_sel_e'(bus_addr))
                SEL_DAT_A: regs_d.rdata = rd_a;
                SEL_DAT_B: regs_d.rdata = rd_b;
                SEL_DIR_A: regs_d.rdata = regs_q.dir_a;
                default:   regs_d.rdata = regs_q.dir_b;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_rdata = regs_q.rdata;
    assign trig_lvl  = trig_mode ? sync_a[TRIG_LO +: 2] : 2'b00;
endmodule

// File: rtl/anpio_port_chk.sv
module anpio_port_chk #(
    parameter logic [7:0] A_MASK  = 8'h1B,
    parameter logic [7:0] B_MASK  = 8'h0F,
    parameter int         MUX_LO  = 0,
    parameter int         TRIG_LO = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       mux_mode,
    input logic [1:0] mux_addr,
    input logic       trig_mode,
    input logic [7:0] pad_a_out,
    input logic [7:0] pad_a_oe,
    input logic [7:0] pad_b_out,
    input logic [7:0] pad_b_oe
);
    a_r4_mux_takes_pins: assert property (@(posedge clk) disable iff (!rst_n)
        mux_mode |-> (pad_a_oe[MUX_LO +: 2] == 2'b11 && pad_a_out[MUX_LO +: 2] == mux_addr));

    a_r6_trig_forces_input: assert property (@(posedge clk) disable iff (!rst_n)
        trig_mode |-> pad_a_oe[TRIG_LO +: 2] == 2'b00);

    a_r2_a_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_a_oe | pad_a_out) & ~A_MASK) == 8'h00);

    a_r3_b_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_b_oe | pad_b_out) & ~B_MASK) == 8'h00);

    a_r3_b_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr[0]) |=> (bus_rdata & ~B_MASK) == 8'h00);

    a_r5_mux_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 2'd0 && mux_mode)
        |=> bus_rdata[MUX_LO +: 2] == $past(mux_addr));

    a_r1_dir_b_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 2'd3) |=> pad_b_oe == ($past(bus_wdata) & B_MASK));

    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

bind anpio_port anpio_port_chk #(
    .A_MASK(A_MASK), .B_MASK(B_MASK), .MUX_LO(MUX_LO), .TRIG_LO(TRIG_LO)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mux_mode(mux_mode), .mux_addr(mux_addr), .trig_mode(trig_mode),
    .pad_a_out(pad_a_out), .pad_a_oe(pad_a_oe),
    .pad_b_out(pad_b_out), .pad_b_oe(pad_b_oe)
);

// File: tb/anpio_port_tb_top.sv
`timescale 1ns/1ps
module anpio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       mux_mode = 1'b0, trig_mode = 1'b0;
    logic [1:0] mux_addr = 2'd0;
    logic [1:0] trig_lvl;
    logic [7:0] pad_a_in = 8'h00, pad_b_in = 8'h00;
    logic [7:0] pad_a_out, pad_a_oe, pad_b_out, pad_b_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    anpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mux_mode(mux_mode), .mux_addr(mux_addr), .trig_mode(trig_mode),
        .trig_lvl(trig_lvl), .pad_a_in(pad_a_in), .pad_a_out(pad_a_out),
        .pad_a_oe(pad_a_oe), .pad_b_in(pad_b_in), .pad_b_out(pad_b_out),
        .pad_b_oe(pad_b_oe));

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] dat;
        logic [7:0] pad;
        logic       mux;
        logic [1:0] maddr;
        logic       trig;
        logic [7:0] exp_rd;
        logic [7:0] exp_oe;
        logic [7:0] exp_out;
        logic [1:0] exp_trig;
    } vec_t;

    // Port A scenarios: dir, dat, pad, mux, maddr, trig -> read, oe, out, trig_lvl
    localparam vec_t VECS [7] = '{
        '{8'h00, 8'hFF, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00, 8'h00, 8'h1B, 2'd0},
        '{8'h1B, 8'h0A, 8'hFF, 1'b0, 2'd0, 1'b0, 8'h0A, 8'h1B, 8'h0A, 2'd0},
        '{8'h00, 8'h00, 8'h5A, 1'b0, 2'd0, 1'b0, 8'h1A, 8'h00, 8'h00, 2'd0},
        '{8'h00, 8'h00, 8'h00, 1'b1, 2'd2, 1'b0, 8'h02, 8'h03, 8'h02, 2'd0},
        '{8'h1B, 8'h1B, 8'h00, 1'b1, 2'd1, 1'b1, 8'h01, 8'h03, 8'h19, 2'd0},
        '{8'h18, 8'h00, 8'h18, 1'b0, 2'd0, 1'b1, 8'h18, 8'h00, 8'h00, 2'd3},
        '{8'h03, 8'h01, 8'h1B, 1'b0, 2'd0, 1'b0, 8'h19, 8'h03, 8'h01, 2'd0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // Read sampled on the next rising edge; result valid on return
    task automatic rd_now(input logic [1:0] a);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        rd_now(a);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R12: reset state
        chk("R1 reset oe A", pad_a_oe, 8'h00);
        chk("R1 reset oe B", pad_b_oe, 8'h00);
        chk("R12 reset rdata", bus_rdata, 8'h00);
        rd(2'd2); chk("R1 reset dir A", bus_rdata, 8'h00);
        rd(2'd3); chk("R1 reset dir B", bus_rdata, 8'h00);

        // Vector table over port A (R4 R5 R6 R7 R8)
        foreach (VECS[i]) begin
            mux_mode = 1'b0; trig_mode = 1'b0;
            wr(2'd2, VECS[i].dir);
            wr(2'd0, VECS[i].dat);
            pad_a_in = VECS[i].pad; mux_mode = VECS[i].mux;
            mux_addr = VECS[i].maddr; trig_mode = VECS[i].trig;
            repeat (3) @(negedge clk);
            chk($sformatf("R4 R6 vec%0d oe", i), pad_a_oe, VECS[i].exp_oe);
            chk($sformatf("R4 R10 vec%0d out", i), pad_a_out, VECS[i].exp_out);
            chk($sformatf("R6 vec%0d trig_lvl", i), {6'd0, trig_lvl}, {6'd0, VECS[i].exp_trig});
            rd(2'd0);
            chk($sformatf("R5 R7 R8 vec%0d read", i), bus_rdata, VECS[i].exp_rd);
        end
        mux_mode = 1'b0; trig_mode = 1'b0;

        // R2: unimplemented port A bits
        wr(2'd2, 8'hFF); rd(2'd2); chk("R2 dir A mask", bus_rdata, 8'h1B);
        chk("R2 oe A mask", pad_a_oe, 8'h1B);
        wr(2'd0, 8'hFF); rd(2'd0); chk("R2 data A mask", bus_rdata, 8'h1B);
        chk("R2 out A mask", pad_a_out, 8'h1B);

        // R3: unimplemented port B bits; output path on B (R8)
        wr(2'd3, 8'hFF); rd(2'd3); chk("R3 dir B mask", bus_rdata, 8'h0F);
        wr(2'd1, 8'hF5); rd(2'd1); chk("R3 R8 data B read", bus_rdata, 8'h05);
        chk("R3 out B", pad_b_out, 8'h05);
        chk("R1 oe B", pad_b_oe, 8'h0F);

        // R11: read data holds while idle
        repeat (3) @(negedge clk);
        chk("R11 rdata hold", bus_rdata, 8'h05);

        // R9: two-flop synchroniser latency on port B input
        wr(2'd3, 8'h00);
        pad_b_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_b_in = 8'h0C;
        rd_now(2'd1); chk("R9 first edge old", bus_rdata, 8'h00);
        rd_now(2'd1); chk("R9 second edge old", bus_rdata, 8'h00);
        rd_now(2'd1); chk("R9 third edge new", bus_rdata, 8'h0C);

        // R10: latch written while input, then made output / override released
        pad_a_in = 8'h00;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h1B);
        repeat (3) @(negedge clk);
        rd(2'd0); chk("R10 input reads pin", bus_rdata, 8'h00);
        chk("R10 still input", pad_a_oe, 8'h00);
        wr(2'd2, 8'h1B);
        rd(2'd0); chk("R10 latch read", bus_rdata, 8'h1B);
        chk("R10 latch on pin", pad_a_out, 8'h1B);
        mux_mode = 1'b1; mux_addr = 2'd0;
        @(negedge clk);
        chk("R4 override out", pad_a_out, 8'h18);
        mux_mode = 1'b0;
        @(negedge clk);
        chk("R10 release restores", pad_a_out, 8'h1B);

        // R11: write takes effect on its edge
        wr(2'd3, 8'h09);
        chk("R11 write dir B", pad_b_oe, 8'h09);

        summary();
        $finish;
    end
endmodule